// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block turns one data-port access request into a correctly timed IDE read or write strobe on the local-bus clock. Two phases make up each access. In the active phase the strobe is held asserted. In the recovery phase both strobes are held deasserted. The length of each phase comes from an 8-bit timing byte: the low field codes the active time and the high nibble codes the recovery time. Both codes are inverse, so a larger code gives a shorter phase. A fixed offset is subtracted from, and that offset depends on the variant and on the bus-speed flag.

Variant A serves one channel. Its active code is 3 bits wide, and both of its offsets change with bus speed. Variant B serves two channels, each with its own timing byte. Its active code is 4 bits wide, and its timing does not depend on bus speed. The requester holds `req` while `busy` is low. It sees `done` in the final cycle of the access. The timing byte is captured when the request is accepted.

The controller has three states.
- `ST_IDLE`: waiting for a request.
- `ST_ACTIVE`: strobe asserted.
- `ST_RECOVER`: strobe released, block still busy.

It has five transitions.
- `ST_IDLE`→`ST_ACTIVE`: a request is accepted.
- `ST_ACTIVE`→`ST_RECOVER`: the active count expires and the recovery count is nonzero.
- `ST_ACTIVE`→`ST_IDLE`: the active count expires, the recovery count is zero, and no request is waiting.
- `ST_ACTIVE`→`ST_ACTIVE`: the active count expires, the recovery count is zero, and a request is waiting (back-to-back).
- `ST_RECOVER`→`ST_IDLE`: the recovery count expires.

Top module: `ide_strobe_gen`

## Requirements
- R1: In variant A (`variant_b`=0) the active code is timing bits [2:0]. The strobe stays low for 8−code clocks when `bus_slow`=1 and for 9−code clocks when `bus_slow`=0. Bit 3 has no effect.
- R2: In variant B (`variant_b`=1) the active code is timing bits [3:0]. The strobe stays low for 17−code clocks at either bus speed.
- R3: In variant A the recovery code is timing bits [7:4]. Recovery lasts 18−code clocks when `bus_slow`=1 and 15−code clocks when `bus_slow`=0, so code 15 at the fast speed gives 0 clocks.
- R4: In variant B recovery lasts 15−code clocks, where the code is bits [7:4]. Codes 14 and 15 give the 2-clock minimum. Bus speed has no effect.
- R5: In variant B, `req_chan`=1 selects `timing_sec` and `req_chan`=0 selects `timing_pri`. In variant A, `timing_pri` is always used and `req_chan` has no effect.
- R6: The timing byte is sampled on the clock edge that accepts the request. A change to it during an access affects only the next access.
- R7: With a zero recovery count, a request held high is accepted on the edge that ends the active phase. The next strobe then follows with no gap, and `busy` stays high.
- R8: `busy` rises on the cycle after acceptance and falls after the last recovery cycle. `done` is high for exactly one cycle, the final cycle of the access. `req` is ignored while the block is in recovery.
- R9: A read (`req_wr`=0) drives `rd_stb_n` low and a write drives `wr_stb_n` low. The other strobe stays high. After reset the block is idle, with `busy`=0, `done`=0 and both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled when the block can accept |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_chan | input | 1 | Channel of the access (variant B): 0 primary, 1 secondary |
| variant_b | input | 1 | 0 = variant A, 1 = variant B |
| bus_slow | input | 1 | 1 = bus at 33 MHz or below, 0 = faster |
| timing_pri | input | 8 | Primary channel timing byte |
| timing_sec | input | 8 | Secondary channel timing byte |
| rd_stb_n | output | 1 | Active-low read strobe |
| wr_stb_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | High in the final cycle of an access |

## Verification
The hardest state to reach from the ports is the zero-recovery back-to-back case. Two strobes merge into one continuous low period, and `busy` must not drop between them. Only variant A at the fast bus speed with recovery code 15 reaches this state. The stimulus sets up that byte and keeps `req` high through the whole first active phase. It then measures a merged low width of twice the active count and two `done` pulses. A second hard case is an update to the timing byte in the middle of an access. To cover it, the bench rewrites the byte on the second strobe cycle and measures both the current access and the following one.

// File: rtl/ide_stb_pkg.sv
package ide_stb_pkg;
    // Longest phase in clocks: variant A slow-bus recovery with code 0
    localparam int MAX_CLKS = 18;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    typedef logic [CNT_W-1:0] clk_cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RECOVER = 2'd2
    } stb_state_t;
endpackage

// File: rtl/ide_time_decode.sv
module ide_time_decode
    import ide_stb_pkg::*;
#(
    parameter int TB_W = 8
) (
    input  logic [TB_W-1:0] timing,
    input  logic            variant_b,
    input  logic            bus_slow,
    output clk_cnt_t        act_clks,
    output clk_cnt_t        rec_clks
);
    localparam int ACT_A_W = 3;
    localparam int ACT_B_W = 4;
    localparam int REC_W   = 4;
    localparam int REC_LSB = TB_W - REC_W;
    localparam int B_REC_FLOOR = 2;
    localparam int B_REC_CLAMP = 14;

    clk_cnt_t code_a, code_b, code_r;

    assign code_a = clk_cnt_t'(timing[ACT_A_W-1:0]);
    assign code_b = clk_cnt_t'(timing[ACT_B_W-1:0]);
    assign code_r = clk_cnt_t'(timing[REC_LSB +: REC_W]);

    always_comb begin
        if (variant_b) begin
            act_clks = clk_cnt_t'(17) - code_b;
            if (code_r >= clk_cnt_t'(B_REC_CLAMP))
                rec_clks = clk_cnt_t'(B_REC_FLOOR);
            else
                rec_clks = clk_cnt_t'(15) - code_r;
        end else begin
            act_clks = (bus_slow ? clk_cnt_t'(8) : clk_cnt_t'(9)) - code_a;
            rec_clks = (bus_slow ? clk_cnt_t'(18) : clk_cnt_t'(15)) - code_r;
        end
    end
endmodule

// File: rtl/ide_phase_counter.sv
module ide_phase_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));

    AST_CNT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R8
endmodule

// File: rtl/ide_strobe_gen.sv
module ide_strobe_gen
    import ide_stb_pkg::*;
#(
    parameter int TB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            req_wr,
    input  logic            req_chan,
    input  logic            variant_b,
    input  logic            bus_slow,
    input  logic [TB_W-1:0] timing_pri,
    input  logic [TB_W-1:0] timing_sec,
    output logic            rd_stb_n,
    output logic            wr_stb_n,
    output logic            busy,
    output logic            done
);
    stb_state_t state, nxt;
    clk_cnt_t   rec_q, dec_act, dec_rec, cnt, load_val;
    logic       wr_q, last, cnt_load, take, act_end, zero_rec;
    logic [TB_W-1:0] sel_timing;

    // Only variant B has a secondary register
    assign sel_timing = (variant_b && req_chan) ? timing_sec : timing_pri;

    ide_time_decode #(.TB_W(TB_W)) u_dec (
        .timing   (sel_timing),
        .variant_b(variant_b),
        .bus_slow (bus_slow),
        .act_clks (dec_act),
        .rec_clks (dec_rec)
    );

    ide_phase_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(load_val),
        .cnt     (cnt),
        .last    (last)
    );

    assign zero_rec = (rec_q == '0);
    assign act_end  = (state == ST_ACTIVE) && last;

    // Next state and counter control
    always_comb begin
        nxt      = state;
        take     = 1'b0;
        cnt_load = 1'b0;
        load_val = dec_act;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    take     = 1'b1;
                    cnt_load = 1'b1;
                    nxt      = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (last) begin
                    if (!zero_rec) begin
                        cnt_load = 1'b1;
                        load_val = rec_q;
                        nxt      = ST_RECOVER;
                    end else if (req) begin
                        take     = 1'b1;
                        cnt_load = 1'b1;
                        nxt      = ST_ACTIVE;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_RECOVER: begin
                if (last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register with per-access captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rec_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (take) begin
                rec_q <= dec_rec;
                wr_q  <= req_wr;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_stb_n = 1'b1;
        wr_stb_n = 1'b1;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_ACTIVE: begin
                rd_stb_n = wr_q;
                wr_stb_n = !wr_q;
                done     = act_end && zero_rec;
            end
            ST_RECOVER: done = last;
            default:    busy = 1'b0;
        endcase
    end

    AST_STB_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_n || !wr_stb_n) |-> busy); // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_stb_n && !wr_stb_n)); // R9
    AST_ACCEPT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> (!rd_stb_n || !wr_stb_n)); // R8
    AST_READ_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && !req_wr) |=> !rd_stb_n); // R9
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req) |=> !busy); // R8
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req && (!rd_stb_n || !wr_stb_n)) |=> (!rd_stb_n || !wr_stb_n)); // R7
endmodule

// File: tb/ide_strobe_gen_test.sv
module ide_strobe_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0, req_chan = 1'b0;
    logic variant_b = 1'b0, bus_slow = 1'b1;
    logic [7:0] timing_pri = 8'h00, timing_sec = 8'h00;
    logic rd_stb_n, wr_stb_n, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ide_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_chan(req_chan),
        .variant_b(variant_b), .bus_slow(bus_slow),
        .timing_pri(timing_pri), .timing_sec(timing_sec),
        .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .busy(busy), .done(done)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Expected counts, written from the requirements
    function automatic int exp_act(input bit vb, input bit slow, input logic [7:0] t);
        if (vb) return 17 - int'(t[3:0]);
        return (slow ? 8 : 9) - int'(t[2:0]);
    endfunction

    function automatic int exp_rec(input bit vb, input bit slow, input logic [7:0] t);
        int c = int'(t[7:4]);
        if (vb) return (c >= 14) ? 2 : 15 - c;
        return (slow ? 18 : 15) - c;
    endfunction

    // One access; counts strobe-low and recovery cycles, done pulses, wrong strobe
    task automatic access(input string rq, input bit wr, input bit chan,
                          input int ea, input int er,
                          input bit poke, input logic [7:0] poke_val);
        int a = 0, r = 0, d = 0, wrong = 0, g = 0;
        bit last_done = 0;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_chan = chan;
        @(negedge clk);
        req = 1'b0;
        while (busy && g < 100) begin
            if (wr ? !wr_stb_n : !rd_stb_n) a++;
            else r++;
            if (wr ? !rd_stb_n : !wr_stb_n) wrong++;
            if (done) d++;
            last_done = done;
            if (poke && a == 2) timing_pri = poke_val;
            g++;
            @(negedge clk);
        end
        chk(rq, "active clocks", a, ea);
        chk(rq, "recovery clocks", r, er);
        chk("R8", "done pulses", d, 1);
        chk("R8", "done in final cycle", int'(last_done), 1);
        chk("R9", "other strobe low cycles", wrong, 0);
    endtask

    task automatic t_reset();
        chk("R9", "busy after reset", int'(busy), 0);
        chk("R9", "rd strobe after reset", int'(rd_stb_n), 1);
        chk("R9", "wr strobe after reset", int'(wr_stb_n), 1);
        chk("R9", "done after reset", int'(done), 0);
    endtask

    task automatic t_variant_a();
        logic [7:0] pats[4] = '{8'h07, 8'hF8, 8'h3A, 8'hC5};
        variant_b = 1'b0;
        foreach (pats[i]) begin
            for (int s = 0; s < 2; s++) begin
                bus_slow = s[0];
                timing_pri = pats[i];
                access("R1", s[0], 1'b0, exp_act(0, s[0], pats[i]), exp_rec(0, s[0], pats[i]), 0, 8'h00);
            end
        end
        // R3: zero recovery at the fast speed with code 15
        bus_slow = 1'b0; timing_pri = 8'hF2;
        access("R3", 1'b0, 1'b0, 7, 0, 0, 8'h00);
    endtask

    task automatic t_variant_b();
        logic [7:0] pats[5] = '{8'h00, 8'hDF, 8'hE5, 8'hF5, 8'h8C};
        variant_b = 1'b1;
        foreach (pats[i]) begin
            for (int s = 0; s < 2; s++) begin
                bus_slow = s[0];
                timing_pri = pats[i];
                access("R2", ~s[0], 1'b0, exp_act(1, 0, pats[i]), exp_rec(1, 0, pats[i]), 0, 8'h00);
            end
        end
        timing_pri = 8'hF0;
        access("R4", 1'b0, 1'b0, 17, 2, 0, 8'h00);
    endtask

    task automatic t_channel();
        variant_b = 1'b1; bus_slow = 1'b1;
        timing_pri = 8'h3C; timing_sec = 8'h9A;
        access("R5", 1'b0, 1'b1, 7, 6, 0, 8'h00);
        access("R5", 1'b1, 1'b0, 5, 12, 0, 8'h00);
        variant_b = 1'b0;
        access("R5", 1'b0, 1'b1, 4, 15, 0, 8'h00);
    endtask

    task automatic t_mid_change();
        variant_b = 1'b1; bus_slow = 1'b0;
        timing_pri = 8'h55;
        access("R6", 1'b0, 1'b0, 12, 10, 1, 8'h0A);
        access("R6", 1'b0, 1'b0, 7, 15, 0, 8'h00);
    endtask

    task automatic t_zero_rec();
        int a = 0, d = 0, g = 0;
        variant_b = 1'b0; bus_slow = 1'b0;
        timing_pri = 8'hF5;   // 4 active, 0 recovery
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0;
        @(negedge clk);
        while (!rd_stb_n && g < 100) begin
            a++;
            if (done) d++;
            chk("R7", "busy during merged strobe", int'(busy), 1);
            if (a == 5) req = 1'b0;
            g++;
            @(negedge clk);
        end
        chk("R7", "merged strobe clocks", a, 8);
        chk("R7", "done pulses", d, 2);
        chk("R7", "busy after second access", int'(busy), 0);
    endtask

    task automatic t_ignore();
        int r = 0, g = 0;
        variant_b = 1'b1; bus_slow = 1'b1;
        timing_pri = 8'h00;   // 17 active, 15 recovery
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0;
        @(negedge clk);
        req = 1'b0;
        while (!rd_stb_n && g < 100) begin g++; @(negedge clk); end
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        r = 1;
        while (busy && g < 200) begin r++; g++; @(negedge clk); end
        chk("R8", "recovery with stray request", r, 15);
        @(negedge clk);
        @(negedge clk);
        chk("R8", "no access from stray request", int'(busy), 0);
        chk("R8", "read strobe idle", int'(rd_stb_n), 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_variant_a();
        t_variant_b();
        t_channel();
        t_mid_change();
        t_zero_rec();
        t_ignore();
        summary();
        $finish;
    end
endmodule